// File: doc/BRIEF.md
# Dual-Mode Decrementer Timer Pair

This block holds two down-counters that share one timebase tick enable. The guest counter can be read in a narrow 32-bit mode or in a wide mode. A single control input picks the mode. The hypervisor counter is always wide. Each counter can be loaded through its own write strobe and data word. Each counter is always visible on a 64-bit read port whose value is sign-extended from the sign bit of the active width.

Each counter drives a registered pending level that is high while its count is negative. The sign bit that decides this is bit 31 in narrow mode and the top bit of the wide count in wide mode. The block also drives the largest positive value each counter can hold in wide mode, as constant outputs. Software uses these constants to park a counter far from expiry.

Top module: `dual_decrementer`

## Requirements
- R1: After reset the guest read port shows 0x000000007FFFFFFF, the hypervisor read port shows its wide maximum, and both pending outputs are 0.
- R2: When `tb_tick` is high and no write is present, a counter drops by exactly one. It passes through zero to all-ones (-1) without saturating. When `tb_tick` is low and no write is present, the counter holds.
- R3: A write in the same cycle as a tick loads the written value, and that value is not decremented in that cycle.
- R4: With `dec_large`=0, a guest write keeps bits 31:0 of the data and fills every higher count bit with data bit 31; data bits 63:32 are ignored. The guest read port shows the count sign-extended from bit 31.
- R5: With `dec_large`=1, a guest write keeps the low DEC_LW bits of the data. The guest read port shows the count sign-extended from bit DEC_LW-1.
- R6: The hypervisor counter ignores `dec_large`. Its writes keep the low HDEC_W bits of the data, and its read port is sign-extended from bit HDEC_W-1.
- R7: Toggling `dec_large` leaves the stored guest count unchanged. Only the read view and the sign test follow the mode.
- R8: Each pending output is a register. At each clock edge it takes the sign of the count stored at that edge, judged with the mode in force at that edge. It therefore falls one cycle after a non-negative value is written.
- R9: `dec_top_val` equals 2^(DEC_LW-1)-1 and `hdec_top_val` equals 2^(HDEC_W-1)-1, zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | Timebase tick enable, decrements both counters |
| dec_large | input | 1 | Guest counter mode: 0 narrow 32-bit, 1 wide |
| dec_wr | input | 1 | Guest counter write strobe |
| dec_wdata | input | 64 | Guest counter write data |
| hdec_wr | input | 1 | Hypervisor counter write strobe |
| hdec_wdata | input | 64 | Hypervisor counter write data |
| dec_rdata | output | 64 | Guest count, sign-extended per mode |
| hdec_rdata | output | 64 | Hypervisor count, sign-extended from its top bit |
| dec_pend | output | 1 | Guest counter negative (registered) |
| hdec_pend | output | 1 | Hypervisor counter negative (registered) |
| dec_top_val | output | 64 | Largest positive guest count in wide mode |
| hdec_top_val | output | 64 | Largest positive hypervisor count |

## Verification
A software load and a timebase tick can arrive in the same cycle on either counter. The bench raises `dec_wr` or `hdec_wr` together with `tb_tick` and expects the loaded value to appear untouched, not one less. The second overlap is a mode change landing on a stored negative narrow value or a wide value with bit 31 set. The bench toggles `dec_large` over idle cycles and checks that the read view and the pending level follow the mode while the count itself is preserved.

// File: rtl/dec_pkg.sv
`timescale 1ns/1ps
package dec_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned NARROW_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  // Largest positive two's-complement value of a given width, zero-extended.
  function automatic word_t pos_limit(input int unsigned width);
    word_t r;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      r[i] = (i + 1 < width) ? 1'b1 : 1'b0;
    end
    return r;
  endfunction

  // Replicates bit 31 above the narrow field.
  function automatic word_t narrow_fill(input word_t d);
    word_t r;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      r[i] = (i < NARROW_W) ? d[i] : d[NARROW_W-1];
    end
    return r;
  endfunction
endpackage

// File: rtl/dec_sign_view.sv
`timescale 1ns/1ps
module dec_sign_view
  import dec_pkg::*;
#(
  parameter int unsigned CNT_W = 48
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             narrow_i,
  output word_t            view_o
);
  localparam int unsigned SIGN_WIDE = CNT_W - 1;
  localparam int unsigned SIGN_NARR = NARROW_W - 1;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i <= SIGN_NARR) begin : g_low
      assign view_o[i] = cnt_i[i];
    end else if (i < CNT_W) begin : g_mid
      assign view_o[i] = narrow_i ? cnt_i[SIGN_NARR] : cnt_i[i];
    end else begin : g_ext
      assign view_o[i] = narrow_i ? cnt_i[SIGN_NARR] : cnt_i[SIGN_WIDE];
    end
  end
endmodule

// File: rtl/dec_counter.sv
`timescale 1ns/1ps
module dec_counter
  import dec_pkg::*;
#(
  parameter int unsigned      CNT_W   = 48,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  logic  narrow_i,
  input  logic  wr_i,
  input  word_t wdata_i,
  output word_t rd_o,
  output logic  neg_o
);
  localparam int unsigned SIGN_WIDE = CNT_W - 1;
  localparam int unsigned SIGN_NARR = NARROW_W - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, load_v;
  logic             neg_q, neg_d;
  logic             cnt_en;

  if (CNT_W < WORD_W) begin : g_hi_unused
    logic unused_hi;
    assign unused_hi = ^wdata_i[WORD_W-1:CNT_W];
  end

  always_comb begin
    word_t filled;
    filled = narrow_fill(wdata_i);
    load_v = narrow_i ? filled[CNT_W-1:0] : wdata_i[CNT_W-1:0];
  end

  // Write wins over tick; clock enable written out.
  always_comb begin
    cnt_en = wr_i | tick_i;
    cnt_d  = cnt_q;
    if (wr_i) begin
      cnt_d = load_v;
    end else if (tick_i) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    neg_d = narrow_i ? cnt_d[SIGN_NARR] : cnt_d[SIGN_WIDE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
    end else begin
      neg_q <= neg_d;
    end
  end

  dec_sign_view #(.CNT_W(CNT_W)) i_view (
    .cnt_i    (cnt_q),
    .narrow_i (narrow_i),
    .view_o   (rd_o)
  );

  assign neg_o = neg_q;

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && tick_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !tick_i) |=> $stable(cnt_q)); // R2
  AST_NARROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && narrow_i) |=> (!narrow_i || rd_o[31:0] == $past(wdata_i[31:0]))); // R3
  AST_NARROW_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && narrow_i) |=> ((cnt_q[SIGN_WIDE:SIGN_NARR] == '0) || (&cnt_q[SIGN_WIDE:SIGN_NARR]))); // R4
  AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !narrow_i) |=> (narrow_i || rd_o[CNT_W-1:0] == $past(wdata_i[CNT_W-1:0]))); // R5
  AST_PEND_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_i == $past(narrow_i)) |-> (neg_o == rd_o[WORD_W-1])); // R8
endmodule

// File: rtl/dual_decrementer.sv
`timescale 1ns/1ps
module dual_decrementer
  import dec_pkg::*;
#(
  parameter int unsigned DEC_LW = 48,
  parameter int unsigned HDEC_W = 56
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tb_tick,
  input  logic        dec_large,
  input  logic        dec_wr,
  input  logic [63:0] dec_wdata,
  input  logic        hdec_wr,
  input  logic [63:0] hdec_wdata,
  output logic [63:0] dec_rdata,
  output logic [63:0] hdec_rdata,
  output logic        dec_pend,
  output logic        hdec_pend,
  output logic [63:0] dec_top_val,
  output logic [63:0] hdec_top_val
);
  localparam word_t DEC_MAX  = pos_limit(DEC_LW);
  localparam word_t HDEC_MAX = pos_limit(HDEC_W);
  localparam word_t NAR_MAX  = pos_limit(NARROW_W);

  localparam logic [DEC_LW-1:0] DEC_RST  = NAR_MAX[DEC_LW-1:0];
  localparam logic [HDEC_W-1:0] HDEC_RST = HDEC_MAX[HDEC_W-1:0];

  logic dec_narrow;
  assign dec_narrow = ~dec_large;

  dec_counter #(.CNT_W(DEC_LW), .RST_VAL(DEC_RST)) i_guest (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tb_tick),
    .narrow_i (dec_narrow),
    .wr_i     (dec_wr),
    .wdata_i  (dec_wdata),
    .rd_o     (dec_rdata),
    .neg_o    (dec_pend)
  );

  // Hypervisor counter is pinned to wide mode.
  dec_counter #(.CNT_W(HDEC_W), .RST_VAL(HDEC_RST)) i_hyp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tb_tick),
    .narrow_i (1'b0),
    .wr_i     (hdec_wr),
    .wdata_i  (hdec_wdata),
    .rd_o     (hdec_rdata),
    .neg_o    (hdec_pend)
  );

  assign dec_top_val  = DEC_MAX;
  assign hdec_top_val = HDEC_MAX;

  AST_HYP_MODE_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdec_wr && !tb_tick) |=> $stable(hdec_rdata)); // R6
  AST_GUEST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_wr && !tb_tick && dec_large && $past(dec_large)) |=> (!dec_large || $stable(dec_rdata))); // R7
endmodule

// File: tb/test_dual_decrementer.sv
`timescale 1ns/1ps
module test_dual_decrementer;
  localparam int DEC_LW = 48;
  localparam int HDEC_W = 56;

  typedef struct {
    logic [63:0] d;
    logic [63:0] h;
    logic        dp;
    logic        hp;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        tb_tick, dec_large, dec_wr, hdec_wr;
  logic [63:0] dec_wdata, hdec_wdata;
  logic [63:0] dec_rdata, hdec_rdata, dec_top_val, hdec_top_val;
  logic        dec_pend, hdec_pend;

  exp_t        sb[$];
  int          total = 0;
  int          bad   = 0;
  int          cycles = 0;

  logic [63:0] m_dec, m_hdec;
  logic        m_dp, m_hp;

  dual_decrementer #(.DEC_LW(DEC_LW), .HDEC_W(HDEC_W)) i_dual_decrementer (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .dec_large(dec_large),
    .dec_wr(dec_wr), .dec_wdata(dec_wdata), .hdec_wr(hdec_wr), .hdec_wdata(hdec_wdata),
    .dec_rdata(dec_rdata), .hdec_rdata(hdec_rdata), .dec_pend(dec_pend), .hdec_pend(hdec_pend),
    .dec_top_val(dec_top_val), .hdec_top_val(hdec_top_val)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] sx(input logic [63:0] v, input int w);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  task automatic wrap_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk64(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle, away from the active edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk64(e.tag, "dec_rdata",  dec_rdata,  e.d);
      chk64(e.tag, "hdec_rdata", hdec_rdata, e.h);
      chk64(e.tag, "dec_pend",   {63'd0, dec_pend},  {63'd0, e.dp});
      chk64(e.tag, "hdec_pend",  {63'd0, hdec_pend}, {63'd0, e.hp});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      wrap_up();
    end
  end

  // Driver: applies inputs, advances the model at the edge, queues the expectation.
  task automatic step(input bit tk, input bit lg, input bit dw, input logic [63:0] dd,
                      input bit hw, input logic [63:0] hd, input string tag);
    exp_t e;
    tb_tick = tk; dec_large = lg; dec_wr = dw; dec_wdata = dd;
    hdec_wr = hw; hdec_wdata = hd;
    @(posedge clk);
    if (dw)      m_dec = lg ? sx(dd, DEC_LW) : sx(dd, 32);
    else if (tk) m_dec = sx(m_dec - 64'd1, DEC_LW);
    if (hw)      m_hdec = sx(hd, HDEC_W);
    else if (tk) m_hdec = sx(m_hdec - 64'd1, HDEC_W);
    m_dp = lg ? m_dec[63] : m_dec[31];
    m_hp = m_hdec[63];
    #1;
    e.d   = lg ? m_dec : sx(m_dec, 32);
    e.h   = m_hdec;
    e.dp  = m_dp;
    e.hp  = m_hp;
    e.tag = tag;
    sb.push_back(e);
    #3;
  endtask

  initial begin
    rst_n = 1'b0;
    tb_tick = 0; dec_large = 0; dec_wr = 0; hdec_wr = 0;
    dec_wdata = '0; hdec_wdata = '0;
    m_dec  = 64'h0000_0000_7FFF_FFFF;
    m_hdec = (64'd1 << (HDEC_W-1)) - 64'd1;
    m_dp = 0; m_hp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #3;
    // R1: reset values
    step(0, 0, 0, 0, 0, 0, "R1");
    // R9: wide maximum constants
    chk64("R9", "dec_top_val",  dec_top_val,  (64'd1 << (DEC_LW-1)) - 64'd1);
    chk64("R9", "hdec_top_val", hdec_top_val, (64'd1 << (HDEC_W-1)) - 64'd1);

    // R2: count down through zero into negative values
    step(0, 0, 1, 64'd3, 1, 64'd3, "R4 load");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R2 tick");
    step(0, 0, 0, 0, 0, 0, "R2 hold at zero");
    step(1, 0, 0, 0, 0, 0, "R2 wrap to -1");
    step(1, 1, 0, 0, 0, 0, "R2 -2 wide");

    // R3: write with tick in the same cycle
    step(1, 0, 1, 64'd100, 1, 64'd200, "R3 write beats tick");
    step(1, 1, 1, 64'd7, 0, 0, "R3 wide write beats tick");

    // R4: narrow write drops upper data bits
    step(0, 0, 1, 64'hABCD_0000_8000_0001, 0, 0, "R4 narrow negative");
    // R7: switch to wide keeps the sign-filled count
    step(0, 1, 0, 0, 0, 0, "R7 narrow value in wide view");

    // R5: wide write with bit 31 set is positive
    step(0, 1, 1, 64'h0000_0000_8000_0000, 0, 0, "R5 wide bit31");
    step(0, 0, 0, 0, 0, 0, "R7 same count narrow view");
    step(0, 1, 0, 0, 0, 0, "R7 back to wide");
    step(0, 1, 1, 64'hFFFF_8000_0000_0000, 0, 0, "R5 wide top bit");
    step(0, 1, 1, 64'd3, 0, 0, "R8 clear after positive write");

    // R4: narrow tick from 0x80000000 turns positive in narrow view
    step(0, 0, 1, 64'h0000_0000_8000_0000, 0, 0, "R4 narrow min");
    step(1, 0, 0, 0, 0, 0, "R4 narrow wrap to max");

    // R6: hypervisor counter ignores the mode input
    step(0, 0, 0, 0, 1, 64'h0000_0000_8000_0000, "R6 hyp bit31 positive");
    step(0, 1, 0, 0, 1, 64'hFF80_0000_0000_0000, "R6 hyp top bit");
    step(0, 0, 0, 0, 0, 0, "R6 hyp mode blind");
    step(0, 0, 0, 0, 1, 64'd5, "R8 hyp clear");
    step(0, 0, 0, 0, 0, 0, "R1 idle");

    wait (sb.size() == 0);
    @(posedge clk);
    wrap_up();
  end
endmodule